// File: doc/BRIEF.md
# Receive Descriptor Walker

This block steps through a list of receive descriptors in memory on behalf of a network receive DMA engine. Each descriptor is four 32-bit words. Word 0 holds an ownership flag and the returned status. Word 1 holds control: two buffer sizes, a link-select bit and an end-of-list bit. Word 2 holds the first buffer address, which may later be replaced by a timestamp. Word 3 holds either a second buffer address or the address of the next descriptor. Software hands a descriptor to the walker by setting its ownership flag. The walker reads the four words through a single-request memory port. It then grants the usable buffers one at a time to a data mover.

When the data mover reports that a buffer is finished, the walker moves to the next buffer. If the buffer closed the frame, or if no buffer is left in the descriptor, the walker writes the status back and returns the descriptor to software. It then moves on to the next descriptor. That next descriptor is at a fixed 16-byte stride, at the address in the link word, or back at the list base after the end-of-list marker. If a fetched descriptor is still held by software, the walker stops, raises a buffer-unavailable flag, and waits for a poll strobe.

Top module: `rx_desc_walker`

## Requirements
- R1: A descriptor is used only when bit 31 of its word 0 reads as 1. When it reads 0, the walker asserts `bufUnavail` and issues no memory request and no grant. It leaves that state only on a `pollDemand` pulse, and then it reads the same word 0 again.
- R2: When the first buffer size in word 1 bits 12:0 is nonzero, the first grant of the descriptor carries the address from word 2 and that size. The grant stays stable until `bufDone`.
- R3: A buffer whose size field is zero is never granted. With a zero first size, the walker goes straight to the second buffer, or to write-back if there is no usable second buffer.
- R4: With word 1 bit 14 set and bit 15 clear, word 3 is the address of the next descriptor. The second size field (bits 28:16) is ignored, and no second buffer is granted.
- R5: Word 1 bit 15 (end of list) overrides bit 14. Word 3 is then treated as a second buffer, and the next descriptor address is `listBase`.
- R6: With bits 15 and 14 both clear, word 3 is the second buffer, and the next descriptor is at the current address plus 16. Descriptor addresses are 16-byte aligned.
- R7: When the buffer that ends a frame is finished with `bufLast` and `bufTsEn` both high, the walker writes `tsLow` into word 2. Otherwise word 2 is never written.
- R8: The walker writes word 0 back as follows: bit 31 = 0, bits 29:16 = the sum of the `bufBytes` reported in this descriptor, bit 9 = first segment, bit 8 = last segment, bit 7 = timestamp stored, and all other bits 0. This write is always the last write to the descriptor.
- R9: A descriptor whose buffers run out before the frame ends is written back with bit 8 clear. The frame continues in the next descriptor, which is written back with bit 9 clear.
- R10: After reset, no memory request, grant or unavailable flag is active. A `startReq` pulse makes the first read go to `listBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | Start walking from the list base |
| pollDemand | input | 1 | Retry after buffer-unavailable stop |
| listBase | input | 32 | Address of the first descriptor |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the descriptor word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted; read data valid this cycle |
| memRdata | input | 32 | Read data |
| bufValid | output | 1 | Buffer granted to the data mover |
| bufAddr | output | 32 | Granted buffer address |
| bufSize | output | 13 | Granted buffer size in bytes |
| bufDone | input | 1 | Data mover finished the granted buffer |
| bufBytes | input | 13 | Bytes written into that buffer |
| bufLast | input | 1 | The buffer holds the end of the frame |
| bufTsEn | input | 1 | Timestamp to be stored for this frame |
| tsLow | input | 32 | Low 32 bits of the frame timestamp |
| bufUnavail | output | 1 | Stopped on a descriptor still owned by software |

## Verification
With the bench memory, every descriptor access takes two cycles: the request cycle and the acknowledge cycle. A grant therefore appears on the cycle after the fourth read is acknowledged. A write-back finishes two or four cycles after the `bufDone` that ended the descriptor, and `bufUnavail` rises two cycles after the next word 0 read is issued. The bench avoids fixed counts. It polls on falling edges, with a bound, for each of these events: the grant, a logged write count, or the flag. It then compares grant outputs and memory contents against values computed from the descriptor words it programmed.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

  localparam int OWN_BIT = 31;
  localparam int EOL_BIT = 15;
  localparam int LINK_BIT = 14;
  localparam int SIZE2_LSB = 16;
  localparam int CNT_LSB = 16;
  localparam int FIRST_BIT = 9;
  localparam int LASTSEG_BIT = 8;
  localparam int TSSTORED_BIT = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_SUSP,
    ST_GR1,
    ST_GR2,
    ST_WTS,
    ST_WST
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       ldBase;
    logic       beginDesc;
    logic       ldCtl;
    logic       ldAddr1;
    logic       ldAddr2;
    logic       bufFin;
    logic       advance;
    logic       selBuf2;
    logic       wrStatus;
    logic [1:0] wordIdx;
  } walkStrobe_t;

endpackage

// File: rtl/rxdw_dpath.sv
module rxdw_dpath
  import rxdw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [31:0]       memRdata,
  input  logic [SIZE_W-1:0] bufBytes,
  input  logic              bufLast,
  input  logic              bufTsEn,
  input  logic [31:0]       tsLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [SIZE_W-1:0] bufSize,
  output logic              ownSeen,
  output logic              size1Nz,
  output logic              buf2Ok
);

  localparam int CNT_W = SIZE_W + 1;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(16);

  logic [ADDR_W-1:0] curDesc;
  logic [31:0]       ctlWord;
  logic [31:0]       addr1Word;
  logic [31:0]       addr2Word;
  logic [31:0]       tsReg;
  logic [CNT_W-1:0]  byteCnt;
  logic              descFirst;
  logic              lastSeg;
  logic              tsStored;
  logic              frameOpen;

  logic [SIZE_W-1:0] size1;
  logic [SIZE_W-1:0] size2;
  logic              endOfList;
  logic              linkMode;
  logic              useBuf2;
  logic [ADDR_W-1:0] nextDesc;
  logic [31:0]       statusWord;

  assign size1     = ctlWord[SIZE_W-1:0];
  assign size2     = ctlWord[SIZE2_LSB +: SIZE_W];
  assign endOfList = ctlWord[EOL_BIT];
  assign linkMode  = ctlWord[LINK_BIT];

  // end-of-list wins over link mode: word 3 is then a buffer
  assign useBuf2 = endOfList | ~linkMode;
  assign size1Nz = (size1 != '0);
  assign buf2Ok  = useBuf2 && (size2 != '0);
  assign ownSeen = memRdata[OWN_BIT];

  always_comb begin
    if (endOfList) nextDesc = listBase;
    else if (linkMode) nextDesc = addr2Word[ADDR_W-1:0];
    else nextDesc = curDesc + STRIDE;
  end

  always_comb begin
    statusWord = '0;
    statusWord[CNT_LSB +: CNT_W] = byteCnt;
    statusWord[FIRST_BIT]    = descFirst;
    statusWord[LASTSEG_BIT]  = lastSeg;
    statusWord[TSSTORED_BIT] = tsStored;
  end

  assign memAddr  = curDesc + ADDR_W'({strb.wordIdx, 2'b00});
  assign memWdata = strb.wrStatus ? statusWord : tsReg;
  assign bufAddr  = strb.selBuf2 ? addr2Word[ADDR_W-1:0] : addr1Word[ADDR_W-1:0];
  assign bufSize  = strb.selBuf2 ? size2 : size1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDesc   <= '0;
      ctlWord   <= '0;
      addr1Word <= '0;
      addr2Word <= '0;
      tsReg     <= '0;
      byteCnt   <= '0;
      descFirst <= 1'b0;
      lastSeg   <= 1'b0;
      tsStored  <= 1'b0;
      frameOpen <= 1'b0;
    end else begin
      if (strb.ldBase) curDesc <= listBase;
      if (strb.beginDesc) begin
        descFirst <= ~frameOpen;
        byteCnt   <= '0;
        lastSeg   <= 1'b0;
        tsStored  <= 1'b0;
      end
      if (strb.ldCtl) ctlWord <= memRdata;
      if (strb.ldAddr1) addr1Word <= memRdata;
      if (strb.ldAddr2) addr2Word <= memRdata;
      if (strb.bufFin) begin
        byteCnt <= byteCnt + CNT_W'(bufBytes);
        if (bufLast) begin
          lastSeg   <= 1'b1;
          frameOpen <= 1'b0;
          if (bufTsEn) begin
            tsReg    <= tsLow;
            tsStored <= 1'b1;
          end
        end else begin
          frameOpen <= 1'b1;
        end
      end
      if (strb.advance) curDesc <= nextDesc;
    end
  end

endmodule

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
  import rxdw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        pollDemand,
  input  logic        memAck,
  input  logic        bufDone,
  input  logic        bufLast,
  input  logic        bufTsEn,
  input  logic        ownSeen,
  input  logic        size1Nz,
  input  logic        buf2Ok,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        bufValid,
  output logic        bufUnavail
);

  walkState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_comb begin
    stateNxt   = state;
    strb       = '0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    bufValid   = 1'b0;
    bufUnavail = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.ldBase = 1'b1;
          stateNxt    = ST_RD0;
        end
      end
      ST_RD0: begin
        memReq = 1'b1;
        strb.wordIdx = 2'd0;
        if (memAck) begin
          if (ownSeen) begin
            strb.beginDesc = 1'b1;
            stateNxt = ST_RD1;
          end else begin
            stateNxt = ST_SUSP;
          end
        end
      end
      ST_RD1: begin
        memReq = 1'b1;
        strb.wordIdx = 2'd1;
        if (memAck) begin
          strb.ldCtl = 1'b1;
          stateNxt = ST_RD2;
        end
      end
      ST_RD2: begin
        memReq = 1'b1;
        strb.wordIdx = 2'd2;
        if (memAck) begin
          strb.ldAddr1 = 1'b1;
          stateNxt = ST_RD3;
        end
      end
      ST_RD3: begin
        memReq = 1'b1;
        strb.wordIdx = 2'd3;
        if (memAck) begin
          strb.ldAddr2 = 1'b1;
          if (size1Nz) stateNxt = ST_GR1;
          else if (buf2Ok) stateNxt = ST_GR2;
          else stateNxt = ST_WST;
        end
      end
      ST_SUSP: begin
        bufUnavail = 1'b1;
        if (pollDemand) stateNxt = ST_RD0;
      end
      ST_GR1: begin
        bufValid = 1'b1;
        if (bufDone) begin
          strb.bufFin = 1'b1;
          if (bufLast) stateNxt = bufTsEn ? ST_WTS : ST_WST;
          else if (buf2Ok) stateNxt = ST_GR2;
          else stateNxt = ST_WST;
        end
      end
      ST_GR2: begin
        bufValid = 1'b1;
        strb.selBuf2 = 1'b1;
        if (bufDone) begin
          strb.bufFin = 1'b1;
          stateNxt = (bufLast && bufTsEn) ? ST_WTS : ST_WST;
        end
      end
      ST_WTS: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strb.wordIdx = 2'd2;
        if (memAck) stateNxt = ST_WST;
      end
      ST_WST: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strb.wordIdx  = 2'd0;
        strb.wrStatus = 1'b1;
        if (memAck) begin
          strb.advance = 1'b1;
          stateNxt = ST_RD0;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rxdw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              pollDemand,
  input  logic [ADDR_W-1:0] listBase,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              bufValid,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [SIZE_W-1:0] bufSize,
  input  logic              bufDone,
  input  logic [SIZE_W-1:0] bufBytes,
  input  logic              bufLast,
  input  logic              bufTsEn,
  input  logic [31:0]       tsLow,
  output logic              bufUnavail
);

  walkStrobe_t strb;
  logic        ownSeen;
  logic        size1Nz;
  logic        buf2Ok;

  rxdw_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .pollDemand (pollDemand),
    .memAck     (memAck),
    .bufDone    (bufDone),
    .bufLast    (bufLast),
    .bufTsEn    (bufTsEn),
    .ownSeen    (ownSeen),
    .size1Nz    (size1Nz),
    .buf2Ok     (buf2Ok),
    .strb       (strb),
    .memReq     (memReq),
    .memWe      (memWe),
    .bufValid   (bufValid),
    .bufUnavail (bufUnavail)
  );

  rxdw_dpath #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .listBase (listBase),
    .memRdata (memRdata),
    .bufBytes (bufBytes),
    .bufLast  (bufLast),
    .bufTsEn  (bufTsEn),
    .tsLow    (tsLow),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .bufAddr  (bufAddr),
    .bufSize  (bufSize),
    .ownSeen  (ownSeen),
    .size1Nz  (size1Nz),
    .buf2Ok   (buf2Ok)
  );

endmodule

// File: rtl/rx_desc_walker_chk.sv
module rx_desc_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              pollDemand,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              bufValid,
  input logic [ADDR_W-1:0] bufAddr,
  input logic [SIZE_W-1:0] bufSize,
  input logic              bufDone,
  input logic              bufUnavail
);

  // R1
  unavail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavail |-> (!memReq && !bufValid));

  // R1
  resume_on_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufUnavail) |-> $past(pollDemand));

  // R3
  nonzero_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |-> (bufSize != '0));

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && !bufDone) |=> (bufValid && $stable(bufAddr) && $stable(bufSize)));

  // R8
  own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAddr[3:0] == 4'h0) |-> !memWdata[31]);

  // R7
  write_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr[3:0] == 4'h0 || memAddr[3:0] == 4'h8));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && bufValid));

endmodule

bind rx_desc_walker rx_desc_walker_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (.*);

// File: tb/rx_desc_walker_tb_top.sv
`timescale 1ns/1ps
module rx_desc_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        pollDemand = 1'b0;
  logic [31:0] listBase = 32'h100;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic        bufValid;
  logic [31:0] bufAddr;
  logic [12:0] bufSize;
  logic        bufDone = 1'b0;
  logic [12:0] bufBytes = '0;
  logic        bufLast = 1'b0;
  logic        bufTsEn = 1'b0;
  logic [31:0] tsLow = '0;
  logic        bufUnavail;

  always #2 clk = ~clk;

  rx_desc_walker dut_i (.*);

  // bench memory, host port and logs
  logic [31:0] mem [0:255];
  logic        hostWe = 1'b0;
  logic [31:0] hostAddr = '0, hostData = '0;
  logic [31:0] wrLog [0:31];
  int          wrCnt = 0;
  int          rdCnt = 0;
  logic [31:0] firstRd = '0, lastRd = '0;

  always @(posedge clk) begin
    if (hostWe) mem[hostAddr[9:2]] <= hostData;
    if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr[9:2]] <= memWdata;
        wrLog[wrCnt[4:0]] <= memAddr;
        wrCnt <= wrCnt + 1;
      end else begin
        memRdata <= mem[memAddr[9:2]];
        if (rdCnt == 0) firstRd <= memAddr;
        lastRd <= memAddr;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3);
    hostWrite(a, w0);
    hostWrite(a + 4, w1);
    hostWrite(a + 8, w2);
    hostWrite(a + 12, w3);
  endtask

  task automatic waitGrant(input string req);
    bit got = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bufValid) begin got = 1; break; end
    end
    check(req, {31'b0, got}, 32'h1);
  endtask

  task automatic finishBuf(input logic [12:0] n, input logic last, input logic ts,
                           input logic [31:0] tsv);
    @(negedge clk);
    bufDone = 1'b1; bufBytes = n; bufLast = last; bufTsEn = ts; tsLow = tsv;
    @(negedge clk);
    bufDone = 1'b0; bufLast = 1'b0; bufTsEn = 1'b0;
  endtask

  task automatic waitWrites(input int n, input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wrCnt >= n) break;
    end
    check(req, wrCnt, n);
  endtask

  task automatic t_reset;
    check("R10 reset memReq", {31'b0, memReq}, 0);
    check("R10 reset bufValid", {31'b0, bufValid}, 0);
    check("R10 reset bufUnavail", {31'b0, bufUnavail}, 0);
  endtask

  // R2 R6 R7 R8: two ring buffers, frame ends in buffer 2 with timestamp
  task automatic t_ringTwoBuf;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    waitGrant("R2 first grant");
    check("R10 first read at listBase", firstRd, 32'h100);
    check("R2 buf1 addr", bufAddr, 32'h2000);
    check("R2 buf1 size", {19'b0, bufSize}, 64);
    finishBuf(64, 0, 0, 0);
    waitGrant("R6 second grant");
    check("R6 buf2 addr", bufAddr, 32'h3000);
    check("R6 buf2 size", {19'b0, bufSize}, 32);
    finishBuf(20, 1, 1, 32'hCAFE1234);
    waitWrites(2, "R7 write count");
    check("R7 ts in word2", mem[8'h42], 32'hCAFE1234);
    check("R8 status word", mem[8'h40], 32'h00540380);
    check("R8 ts write first", wrLog[0], 32'h108);
    check("R8 word0 write last", wrLog[1], 32'h100);
  endtask

  // R3 R6: zero first size skipped, stride to next descriptor
  task automatic t_skipZero;
    waitGrant("R3 grant");
    check("R3 skip to buf2 addr", bufAddr, 32'h3100);
    check("R3 buf2 size", {19'b0, bufSize}, 48);
    finishBuf(40, 1, 0, 32'h11111111);
    waitWrites(3, "R7 no ts write");
    check("R7 word2 untouched", mem[8'h46], 32'h2100);
    check("R8 status no ts", mem[8'h44], 32'h00280300);
  endtask

  // R4 R9: linked descriptor, size2 ignored, frame continues
  task automatic t_chain;
    waitGrant("R4 grant");
    check("R4 buf1 addr", bufAddr, 32'h2200);
    check("R4 buf1 size", {19'b0, bufSize}, 16);
    finishBuf(16, 0, 0, 0);
    waitWrites(4, "R4 writeback");
    check("R9 status not last", mem[8'h48], 32'h00100200);
    check("R4 only word0 written", wrLog[3], 32'h120);
  endtask

  // R5 R9 R7: end of list with link bit, word3 is buffer, wrap to base
  task automatic t_endList;
    waitGrant("R4 link followed");
    check("R4 next desc via link", bufAddr, 32'h2300);
    check("R5 buf1 size", {19'b0, bufSize}, 8);
    finishBuf(8, 0, 0, 0);
    waitGrant("R5 buf2 grant");
    check("R5 word3 used as buffer", bufAddr, 32'h3300);
    check("R5 buf2 size", {19'b0, bufSize}, 24);
    finishBuf(10, 1, 1, 32'h0BADF00D);
    waitWrites(6, "R5 writeback");
    check("R7 ts stored", mem[8'h62], 32'h0BADF00D);
    check("R9 continued status", mem[8'h60], 32'h00120180);
    check("R8 word0 last", wrLog[5], 32'h180);
  endtask

  // R1 R5: wrap to base, descriptor not owned, suspend, then poll
  task automatic t_suspendPoll;
    int rdSnap;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bufUnavail) break;
    end
    check("R1 unavailable raised", {31'b0, bufUnavail}, 1);
    check("R5 wrapped to listBase", lastRd, 32'h100);
    rdSnap = rdCnt;
    repeat (10) @(negedge clk);
    check("R1 no reads while stopped", rdCnt, rdSnap);
    check("R1 still unavailable", {31'b0, bufUnavail}, 1);
    putDesc(32'h100, 32'h80000000, 32'h00000020, 32'h4000, 32'h4100);
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    check("R1 flag drops after poll", {31'b0, bufUnavail}, 0);
    waitGrant("R1 resume grant");
    check("R1 reread base desc", bufAddr, 32'h4000);
    check("R1 size after poll", {19'b0, bufSize}, 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    putDesc(32'h100, 32'h80000000, 32'h00200040, 32'h2000, 32'h3000);
    putDesc(32'h110, 32'h80000000, 32'h00300000, 32'h2100, 32'h3100);
    putDesc(32'h120, 32'h80000000, 32'h00644010, 32'h2200, 32'h180);
    putDesc(32'h180, 32'h80000000, 32'h0018C008, 32'h2300, 32'h3300);
    t_reset();
    t_ringTwoBuf();
    t_skipZero();
    t_chain();
    t_endList();
    t_suspendPoll();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule